// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

The resolver turns the addressing part of an interrupt message into a bitmask with one bit per local interrupt unit. A request carries an 8-bit destination, a bit that selects physical or logical addressing, a 2-bit shorthand, the index of the sending unit and a 3-bit delivery mode. The resolver walks the units one per clock and compares the request with each unit's physical ID, logical destination, destination model and populated flag. Those come in as flat per-unit tables on input pins. When the walk ends it presents the finished mask. For lowest-priority delivery the mask keeps only the lowest-numbered unit that would otherwise have been hit.

Requests enter over a valid/ready channel and results leave over a second valid/ready channel. The block handles one request at a time. `req_ready` is high only while the block is idle. After a result is presented, it is held until the consumer raises `res_ready`. A consumer that keeps `res_ready` low stalls the resolver, and no new request is accepted during that time. The unit tables must stay stable from acceptance until the result is taken. Unit k sits in bits `[8k+7:8k]` of the ID and logical destination tables, in bits `[4k+3:4k]` of the model table, and in bit k of the populated vector and of the result mask.

Top module: `dest_resolver`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and `res_mask` is all zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the result is taken. `res_valid` rises exactly NUM_UNITS cycles after the edge that accepted the request.
- R3: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_mask` does not change. The result is taken on an edge with `res_ready` high, and `req_ready` returns to 1 after that edge.
- R4: The shorthand code selects the targets. Code 1 hits only the unit whose index equals `req_sender`. Code 2 hits every configured unit. Code 3 hits every configured unit except the sender. With codes 1 to 3, the destination and addressing-mode fields have no effect. A sender index at or beyond NUM_UNITS matches no unit.
- R5: With shorthand 0 and physical addressing (`req_logical`=0), destination 0xFF sets every configured unit's bit, whether or not the unit is populated.
- R6: With shorthand 0, physical addressing and any destination other than 0xFF, the block sets at most one bit. That bit belongs to the lowest-indexed populated unit whose physical ID equals the destination. If no such unit exists, the mask is zero.
- R7: With shorthand 0 and logical addressing, a unit with model code 0xF matches when the destination ANDed with its logical destination is nonzero.
- R8: With shorthand 0 and logical addressing, a unit with model code 0x0 matches when the upper nibbles of the destination and its logical destination are equal and the AND of their lower nibbles is nonzero. Any other model code never matches.
- R9: Under logical addressing, the walk stops at the first unit whose populated flag is 0. That unit and every higher-indexed unit stay clear, even when they would match.
- R10: With delivery mode code 1 (lowest priority), only the lowest-numbered bit of the mask that would otherwise be produced remains set. Other delivery mode codes leave the mask unchanged.
- R11: A unit left in its reset-time logical setup (logical destination 0x00, model 0xF) never matches a logical request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_sender | input | 8 | Index of the sending unit |
| req_dmode | input | 3 | Delivery mode, code 1 = lowest priority |
| unit_phys_id | input | 8*NUM_UNITS | Physical ID per unit |
| unit_log_dest | input | 8*NUM_UNITS | Logical destination per unit |
| unit_model | input | 4*NUM_UNITS | Destination model per unit |
| unit_present | input | NUM_UNITS | Unit populated flag |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_mask | output | NUM_UNITS | Target bitmask, bit k = unit k |

## Verification
The bench builds the resolver with NUM_UNITS = 6. With that value, sender index 7 lies outside the unit range, and an index counter sized for eight units shows whether it stays within six. The bench's table places two units with the same physical ID, a mix of flat and cluster units, and holes in the populated vector. These bring the lowest-index tie-break, both logical match rules and the early stop of the logical walk within reach in a few requests each.

// File: rtl/dest_resolve_pkg.sv
package dest_resolve_pkg;
  localparam int UNIT_ID_W = 8;
  localparam int MODEL_W   = 4;
  localparam int DMODE_W   = 3;
  localparam int NIB_W     = UNIT_ID_W / 2;

  typedef enum logic [1:0] {
    SH_FIELD        = 2'd0,
    SH_SELF         = 2'd1,
    SH_ALL          = 2'd2,
    SH_ALL_BUT_SELF = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_e;

  localparam logic [MODEL_W-1:0]   MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0]   MODEL_CLUSTER = 4'h0;
  localparam logic [UNIT_ID_W-1:0] DEST_BCAST    = 8'hFF;
  localparam logic [DMODE_W-1:0]   DMODE_LOWEST  = 3'd1;

  typedef struct packed {
    logic [UNIT_ID_W-1:0] dest;
    logic                 logical;
    shorthand_e           sh;
    logic [UNIT_ID_W-1:0] sender;
    logic [DMODE_W-1:0]   dmode;
  } route_req_t;
endpackage

// File: rtl/dest_unit_match.sv
module dest_unit_match
  import dest_resolve_pkg::*;
(
  input  route_req_t           req,
  input  logic [UNIT_ID_W-1:0] unit_idx,
  input  logic                 unit_present,
  input  logic [UNIT_ID_W-1:0] unit_id,
  input  logic [UNIT_ID_W-1:0] unit_ldest,
  input  logic [MODEL_W-1:0]   unit_model,
  input  logic                 gap_seen,
  output logic                 hit
);
  logic flat_hit, cluster_hit, logical_hit, phys_hit;

  always_comb begin
    flat_hit    = (unit_model == MODEL_FLAT) && (|(req.dest & unit_ldest));
    cluster_hit = (unit_model == MODEL_CLUSTER)
               && (req.dest[UNIT_ID_W-1:NIB_W] == unit_ldest[UNIT_ID_W-1:NIB_W])
               && (|(req.dest[NIB_W-1:0] & unit_ldest[NIB_W-1:0]));
    logical_hit = unit_present && !gap_seen && (flat_hit || cluster_hit);
    phys_hit    = (req.dest == DEST_BCAST) || (unit_present && (unit_id == req.dest));
    case (req.sh)
      SH_FIELD: hit = req.logical ? logical_hit : phys_hit;
      SH_SELF:  hit = (unit_idx == req.sender);
      SH_ALL:   hit = 1'b1;
      default:  hit = (unit_idx != req.sender);
    endcase
  end
endmodule

// File: rtl/dest_scan_ctrl.sv
module dest_scan_ctrl
  import dest_resolve_pkg::*;
#(
  parameter  int NUM_UNITS = 8,
  localparam int CNT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             accept,
  output logic             scan_en,
  output logic [CNT_W-1:0] scan_idx
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_UNITS - 1);

  scan_state_e state_q;
  logic [CNT_W-1:0] idx_q;

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_DONE);
  assign scan_en   = (state_q == ST_SCAN);
  assign accept    = req_valid && req_ready;
  assign scan_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
        end
        ST_SCAN: if (idx_q == LAST_IDX) state_q <= ST_DONE;
                 else idx_q <= idx_q + 1'b1;
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dest_mask_accum.sv
module dest_mask_accum #(
  parameter  int NUM_UNITS = 8,
  localparam int CNT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 scan_en,
  input  logic [CNT_W-1:0]     scan_idx,
  input  logic                 unit_hit,
  input  logic                 unit_present,
  input  logic                 single_target,
  output logic [NUM_UNITS-1:0] mask,
  output logic                 gap_seen
);
  logic [NUM_UNITS-1:0] mask_q;
  logic gap_q;
  logic take;

  assign take     = scan_en && unit_hit && !(single_target && (|mask_q));
  assign mask     = mask_q;
  assign gap_seen = gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      gap_q  <= 1'b0;
    end else if (accept) begin
      mask_q <= '0;
      gap_q  <= 1'b0;
    end else if (scan_en) begin
      if (!unit_present) gap_q <= 1'b1;
      for (int k = 0; k < NUM_UNITS; k++) begin
        if (take && (scan_idx == CNT_W'(k))) mask_q[k] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dest_resolver.sv
module dest_resolver
  import dest_resolve_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [UNIT_ID_W-1:0]           req_dest,
  input  logic                           req_logical,
  input  logic [1:0]                     req_shorthand,
  input  logic [UNIT_ID_W-1:0]           req_sender,
  input  logic [DMODE_W-1:0]             req_dmode,
  input  logic [NUM_UNITS*UNIT_ID_W-1:0] unit_phys_id,
  input  logic [NUM_UNITS*UNIT_ID_W-1:0] unit_log_dest,
  input  logic [NUM_UNITS*MODEL_W-1:0]   unit_model,
  input  logic [NUM_UNITS-1:0]           unit_present,
  output logic                           res_valid,
  input  logic                           res_ready,
  output logic [NUM_UNITS-1:0]           res_mask
);
  localparam int CNT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

  logic             accept, scan_en, gap_seen, unit_hit, single_target;
  logic [CNT_W-1:0] scan_idx;
  route_req_t       req_q;

  logic [UNIT_ID_W-1:0] id_arr [NUM_UNITS];
  logic [UNIT_ID_W-1:0] ld_arr [NUM_UNITS];
  logic [MODEL_W-1:0]   md_arr [NUM_UNITS];

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unpack
    assign id_arr[g] = unit_phys_id[g*UNIT_ID_W +: UNIT_ID_W];
    assign ld_arr[g] = unit_log_dest[g*UNIT_ID_W +: UNIT_ID_W];
    assign md_arr[g] = unit_model[g*MODEL_W +: MODEL_W];
  end

  logic [UNIT_ID_W-1:0] cur_id, cur_ld;
  logic [MODEL_W-1:0]   cur_md;
  logic                 cur_pr;

  always_comb begin
    cur_id = '0;
    cur_ld = '0;
    cur_md = '0;
    cur_pr = 1'b0;
    for (int k = 0; k < NUM_UNITS; k++) begin
      if (scan_idx == CNT_W'(k)) begin
        cur_id = id_arr[k];
        cur_ld = ld_arr[k];
        cur_md = md_arr[k];
        cur_pr = unit_present[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (accept) begin
      req_q.dest    <= req_dest;
      req_q.logical <= req_logical;
      req_q.sh      <= shorthand_e'(req_shorthand);
      req_q.sender  <= req_sender;
      req_q.dmode   <= req_dmode;
    end
  end

  assign single_target = (req_q.dmode == DMODE_LOWEST)
                      || ((req_q.sh == SH_FIELD) && !req_q.logical && (req_q.dest != DEST_BCAST));

  dest_scan_ctrl #(.NUM_UNITS(NUM_UNITS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .accept    (accept),
    .scan_en   (scan_en),
    .scan_idx  (scan_idx)
  );

  dest_unit_match match_i (
    .req          (req_q),
    .unit_idx     (UNIT_ID_W'(scan_idx)),
    .unit_present (cur_pr),
    .unit_id      (cur_id),
    .unit_ldest   (cur_ld),
    .unit_model   (cur_md),
    .gap_seen     (gap_seen),
    .hit          (unit_hit)
  );

  dest_mask_accum #(.NUM_UNITS(NUM_UNITS)) accum_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .scan_en       (scan_en),
    .scan_idx      (scan_idx),
    .unit_hit      (unit_hit),
    .unit_present  (cur_pr),
    .single_target (single_target),
    .mask          (res_mask),
    .gap_seen      (gap_seen)
  );
endmodule

// File: rtl/dest_resolver_chk.sv
module dest_resolver_chk #(
  parameter int NUM_UNITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [NUM_UNITS-1:0] res_mask,
  input logic                 single_target
);
  logic [8:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (req_valid && req_ready) lat_cnt <= '0;
    else if (!req_ready && !res_valid) lat_cnt <= lat_cnt + 1'b1;
  end

  // R2
  idle_or_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (lat_cnt == 9'(NUM_UNITS)));

  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_mask)));

  // R10
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && single_target) |-> $onehot0(res_mask));
endmodule

bind dest_resolver dest_resolver_chk #(.NUM_UNITS(NUM_UNITS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_mask      (res_mask),
  .single_target (single_target)
);

// File: tb/dest_resolver_tb_top.sv
module dest_resolver_tb_top;
  localparam int NU = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_ready, req_logical = 1'b0;
  logic [7:0]    req_dest = '0, req_sender = '0;
  logic [1:0]    req_shorthand = '0;
  logic [2:0]    req_dmode = '0;
  logic [NU*8-1:0] unit_phys_id, unit_log_dest;
  logic [NU*4-1:0] unit_model;
  logic [NU-1:0]   unit_present;
  logic          res_valid, res_ready = 1'b0;
  logic [NU-1:0] res_mask;

  int n_checks = 0, n_fail = 0;

  dest_resolver #(.NUM_UNITS(NU)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_shorthand(req_shorthand),
    .req_sender(req_sender), .req_dmode(req_dmode), .unit_phys_id(unit_phys_id),
    .unit_log_dest(unit_log_dest), .unit_model(unit_model), .unit_present(unit_present),
    .res_valid(res_valid), .res_ready(res_ready), .res_mask(res_mask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_unit(input int k, input logic [7:0] id, input logic [7:0] ld,
                          input logic [3:0] md, input logic pr);
    unit_phys_id[k*8 +: 8]  = id;
    unit_log_dest[k*8 +: 8] = ld;
    unit_model[k*4 +: 4]    = md;
    unit_present[k]         = pr;
  endtask

  task automatic init_tables();
    set_unit(0, 8'h10, 8'h01, 4'hF, 1'b1);
    set_unit(1, 8'h11, 8'h02, 4'hF, 1'b1);
    set_unit(2, 8'h12, 8'h04, 4'hF, 1'b1);
    set_unit(3, 8'h13, 8'h21, 4'h0, 1'b1);
    set_unit(4, 8'h12, 8'h22, 4'h0, 1'b1);
    set_unit(5, 8'h15, 8'h31, 4'h0, 1'b1);
  endtask

  task automatic run_req(input logic [1:0] sh, input logic lg, input logic [7:0] dest,
                         input logic [7:0] sender, input logic [2:0] dm,
                         output logic [NU-1:0] mask, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_shorthand = sh; req_logical = lg; req_dest = dest;
    req_sender = sender; req_dmode = dm; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid) begin
      @(negedge clk);
      lat++;
    end
    mask = res_mask;
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic expect_mask(input string tag, input logic [1:0] sh, input logic lg,
                             input logic [7:0] dest, input logic [7:0] sender,
                             input logic [2:0] dm, input logic [NU-1:0] exp);
    logic [NU-1:0] m;
    int lat;
    run_req(sh, lg, dest, sender, dm, m, lat);
    check(tag, 32'(m), 32'(exp));
  endtask

  task automatic t_reset();
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 res_mask", 32'(res_mask), 32'd0);
  endtask

  task automatic t_handshake();
    logic [NU-1:0] m;
    int lat;
    run_req(2'd2, 1'b0, 8'h00, 8'd0, 3'd0, m, lat);
    check("R2 latency", 32'(lat), 32'(NU));
    check("R3 released", 32'(res_valid), 32'd0);
    check("R3 ready again", 32'(req_ready), 32'd1);
  endtask

  task automatic t_backpressure();
    logic [NU-1:0] first;
    @(negedge clk);
    req_shorthand = 2'd3; req_logical = 1'b0; req_dest = 8'h00;
    req_sender = 8'd1; req_dmode = 3'd0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 busy", 32'(req_ready), 32'd0);
    req_shorthand = 2'd1;
    while (!res_valid) @(negedge clk);
    first = res_mask;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3 hold valid", 32'(res_valid), 32'd1);
      check("R3 hold mask", 32'(res_mask), 32'(first));
      check("R2 no accept while held", 32'(req_ready), 32'd0);
    end
    check("R4 all but sender", 32'(first), 32'h3D);
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    check("R3 taken", 32'(res_valid), 32'd0);
  endtask

  task automatic t_shorthand();
    expect_mask("R4 self", 2'd1, 1'b1, 8'hFF, 8'd4, 3'd0, 6'h10);
    expect_mask("R4 all", 2'd2, 1'b1, 8'h00, 8'd0, 3'd0, 6'h3F);
    expect_mask("R4 all but 2", 2'd3, 1'b0, 8'h12, 8'd2, 3'd0, 6'h3B);
    expect_mask("R4 sender out of range", 2'd3, 1'b0, 8'h00, 8'd7, 3'd0, 6'h3F);
    expect_mask("R4 self out of range", 2'd1, 1'b0, 8'h00, 8'd7, 3'd0, 6'h00);
  endtask

  task automatic t_physical();
    expect_mask("R5 broadcast", 2'd0, 1'b0, 8'hFF, 8'd0, 3'd0, 6'h3F);
    expect_mask("R6 duplicate id", 2'd0, 1'b0, 8'h12, 8'd0, 3'd0, 6'h04);
    expect_mask("R6 no match", 2'd0, 1'b0, 8'h99, 8'd0, 3'd0, 6'h00);
    unit_present[1] = 1'b0;
    expect_mask("R5 broadcast with hole", 2'd0, 1'b0, 8'hFF, 8'd0, 3'd0, 6'h3F);
    expect_mask("R6 absent unit", 2'd0, 1'b0, 8'h11, 8'd0, 3'd0, 6'h00);
    expect_mask("R6 past hole", 2'd0, 1'b0, 8'h15, 8'd0, 3'd0, 6'h20);
    init_tables();
  endtask

  task automatic t_logical();
    expect_mask("R7 flat", 2'd0, 1'b1, 8'h05, 8'd0, 3'd0, 6'h05);
    expect_mask("R8 cluster and flat", 2'd0, 1'b1, 8'h23, 8'd0, 3'd0, 6'h1B);
    expect_mask("R8 cluster upper", 2'd0, 1'b1, 8'h31, 8'd0, 3'd0, 6'h21);
  endtask

  task automatic t_lowest();
    expect_mask("R10 lowest logical", 2'd0, 1'b1, 8'h23, 8'd0, 3'd1, 6'h01);
    expect_mask("R10 lowest all but self", 2'd3, 1'b0, 8'h00, 8'd0, 3'd1, 6'h02);
    expect_mask("R10 lowest empty", 2'd0, 1'b0, 8'h99, 8'd0, 3'd1, 6'h00);
    expect_mask("R10 other mode", 2'd0, 1'b1, 8'h23, 8'd0, 3'd4, 6'h1B);
  endtask

  task automatic t_gap();
    unit_present[1] = 1'b0;
    expect_mask("R9 stop at hole", 2'd0, 1'b1, 8'h23, 8'd0, 3'd0, 6'h01);
    unit_present[1] = 1'b1;
    unit_present[3] = 1'b0;
    expect_mask("R9 stop at unit 3", 2'd0, 1'b1, 8'h23, 8'd0, 3'd0, 6'h03);
    init_tables();
  endtask

  task automatic t_unprogrammed();
    set_unit(0, 8'h10, 8'h00, 4'hF, 1'b1);
    set_unit(2, 8'h12, 8'h04, 4'h5, 1'b1);
    expect_mask("R11 reset-state unit and R8 odd model", 2'd0, 1'b1, 8'hFF, 8'd0, 3'd0, 6'h02);
    init_tables();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    init_tables();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_handshake();
    t_backpressure();
    t_shorthand();
    t_physical();
    t_logical();
    t_lowest();
    t_gap();
    t_unprogrammed();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule